// File: doc/BRIEF.md
# Page-Fetch DMA Engine

This block sits in a disk controller and moves one page of words from main memory into the controller's local cache RAM without the CPU. The CPU starts a transfer with one bus write. The controller's device ID goes on the address lines, a command word goes on the control lines, and the physical page address goes on the data lines. The engine takes the command only when the ID matches and it is not already working. It then raises a bus request and waits for a grant. While it holds the grant, it reads main memory one word at a time, stepping the address by one word (4 bytes) each time. Every returned word is written into the local RAM at the slot base plus the word offset.

Each read is a level request, `mem_read`, that stays high until memory answers with `mem_ack` in the same cycle. In that cycle the word is written straight through to the local RAM port. If the grant is taken away part way through a page, the engine stops issuing reads and keeps its place. When the grant comes back, it carries on from the same word. After the last word the engine drops its request, pulses `done` for one cycle and goes idle.

The command word has this layout: bit 0 is the transfer direction flag, bits [SLOT_W:1] select the local RAM slot, and bit CMD_W-1 is the start bit. With the defaults (CMD_W = 4, 4 slots, 16-word pages) bits 2:1 are the slot and bit 3 is the start bit. The direction flag is kept and reported for the disk side. The copy path itself always runs from memory to the local RAM.

Top module: `dma_page_copy`

## Requirements
- R1: During and right after synchronous active-low reset, `busy`, `bus_req`, `mem_read`, `lm_we` and `done` are all low.
- R2: A command is taken only when `cmd_valid` is high, `cmd_addr` equals the DEV_ID parameter, start bit CMD_W-1 of `cmd_ctrl` is 1 and the engine is idle. Any other command leaves `busy` and `bus_req` low.
- R3: In the cycle after a command is taken, `bus_req` is high. `mem_read` stays low until `bus_grant` has been seen.
- R4: `mem_read` is high only while `bus_grant` is high. Its address is the page address plus 4 times the current word offset, starting at offset 0.
- R5: In a cycle with `mem_read` and `mem_ack` both high, `lm_we` is high, `lm_addr` is slot × PAGE_WORDS + offset and `lm_wdata` equals `mem_rdata`. After a transfer, the slot holds the whole page in order.
- R6: While the grant is withdrawn, no word is taken, even if `mem_ack` is high. The offset and `mem_addr` are held, and the transfer resumes at the same word.
- R7: One cycle after the final word is written, `done` is high for exactly one cycle, with `busy` and `bus_req` low. Exactly PAGE_WORDS words are written per command.
- R8: `busy` is high from the cycle after a command is taken until the final word is written.
- R9: A command that arrives while the engine is busy is ignored. The page address, slot and direction of the running transfer are unchanged.
- R10: `dir` takes the value of `cmd_ctrl` bit 0 when a command is taken and holds it until the next command is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | CPU command write strobe |
| cmd_addr | input | ADDR_W | Address bus during the command: device ID |
| cmd_ctrl | input | CMD_W | Control bus during the command: start, slot, direction |
| cmd_data | input | ADDR_W | Data bus during the command: physical page address |
| bus_req | output | 1 | System bus request |
| bus_grant | input | 1 | System bus grant from the arbiter |
| mem_addr | output | ADDR_W | Main memory read address |
| mem_read | output | 1 | Main memory read request, held until acknowledged |
| mem_ack | input | 1 | Main memory read data valid |
| mem_rdata | input | DATA_W | Main memory read data |
| lm_we | output | 1 | Local cache RAM write enable |
| lm_addr | output | LM_AW | Local cache RAM word address |
| lm_wdata | output | DATA_W | Local cache RAM write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-page pulse |
| dir | output | 1 | Direction flag of the last accepted command |

## Verification
The assertions watch every cycle for these rules: no read without the grant, a held read address between word captures, a direction flag that is stable while busy, a single-cycle `done` with the request already dropped, and a word count equal to the page length at `done`. Some behaviour can only be shown by the bench's scenarios. These are: the exact address sequence, that the local RAM ends up holding the right page in the right slot, that foreign or start-less commands are rejected, that commands issued mid-transfer are ignored, and that the transfer resumes at the same word after random grant drops and delayed acknowledges.

// File: rtl/dma_pkg.sv
`timescale 1ns/1ps
// Shared types for the page-fetch DMA engine.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package dma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_XFER = 2'd2,
        ST_DONE = 2'd3
    } dma_state_e;
endpackage

// File: rtl/dma_cmd_decode.sv
`timescale 1ns/1ps
// Command decoder: recognises a CPU write addressed to this controller
// and splits the control word into start, slot and direction fields.
// Assumes: the control word is laid out as {start, ..., slot, dir}, with
// the slot field directly above bit 0 and CMD_W >= SLOT_W + 2.
module dma_cmd_decode #(
    parameter int ADDR_W = 32,
    parameter int CMD_W  = 4,
    parameter int SLOT_W = 2,
    parameter logic [ADDR_W-1:0] DEV_ID = 'hA3
) (
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [CMD_W-1:0]  cmd_ctrl,
    input  logic              idle,
    output logic              accept,
    output logic              dir_bit,
    output logic [SLOT_W-1:0] slot
);
    localparam int START_BIT = CMD_W - 1;

    logic id_hit;

    // Match the device ID and qualify with start bit and idle state.
    always_comb begin
        id_hit  = (cmd_addr == DEV_ID);
        accept  = cmd_valid && id_hit && cmd_ctrl[START_BIT] && idle;
        dir_bit = cmd_ctrl[0];
        slot    = cmd_ctrl[SLOT_W:1];
    end
endmodule

// File: rtl/dma_seq_fsm.sv
`timescale 1ns/1ps
// Transfer sequencer: idle -> request bus -> copy words -> done pulse.
// Assumes: last_word is valid in every copy cycle, and a word is taken
// only in a cycle where the read request and the acknowledge coincide.
module dma_seq_fsm
    import dma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic bus_grant,
    input  logic mem_ack,
    input  logic last_word,
    output logic bus_req,
    output logic mem_read,
    output logic word_take,
    output logic busy,
    output logic done,
    output logic idle
);
    dma_state_e state_q, state_d;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)                 state_d = ST_REQ;
            ST_REQ:  if (bus_grant)              state_d = ST_XFER;
            ST_XFER: if (word_take && last_word) state_d = ST_DONE;
            ST_DONE:                             state_d = ST_IDLE;
            default:                             state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs decoded from the state and the live grant.
    always_comb begin
        bus_req   = (state_q == ST_REQ) || (state_q == ST_XFER);
        busy      = bus_req;
        mem_read  = (state_q == ST_XFER) && bus_grant;
        word_take = mem_read && mem_ack;
        done      = (state_q == ST_DONE);
        idle      = (state_q == ST_IDLE);
    end
endmodule

// File: rtl/dma_addr_gen.sv
`timescale 1ns/1ps
// Address generator: holds the running main-memory address, the word
// offset, the local slot base and the direction flag of one transfer.
// Assumes: load and step never occur in the same cycle (load only when idle).
module dma_addr_gen #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_WORDS = 16,
    parameter int WORD_BYTES = 4,
    parameter int SLOT_W     = 2,
    parameter int OFF_W      = 4,
    parameter int LM_AW      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] page_addr,
    input  logic [SLOT_W-1:0] slot,
    input  logic              dir_in,
    input  logic              step,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LM_AW-1:0]  lm_addr,
    output logic              last_word,
    output logic              dir
);
    localparam bit PAGE_POW2 = ((1 << OFF_W) == PAGE_WORDS);

    logic [ADDR_W-1:0] addr_q;
    logic [OFF_W-1:0]  off_q;
    logic [LM_AW-1:0]  base_q;
    logic [LM_AW-1:0]  base_calc;
    logic              dir_q;

    // Slot base: a shift when the page is a power of two, a multiply otherwise.
    generate
        if (PAGE_POW2) begin : g_base_shift
            assign base_calc = LM_AW'({slot, {OFF_W{1'b0}}});
        end else begin : g_base_mul
            assign base_calc = LM_AW'(slot) * LM_AW'(PAGE_WORDS);
        end
    endgenerate

    // Transfer registers: load on command, advance one word per capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            off_q  <= '0;
            base_q <= '0;
            dir_q  <= 1'b0;
        end else if (load) begin
            addr_q <= page_addr;
            off_q  <= '0;
            base_q <= base_calc;
            dir_q  <= dir_in;
        end else if (step) begin
            addr_q <= addr_q + ADDR_W'(WORD_BYTES);
            off_q  <= off_q + 1'b1;
        end
    end

    // Output addresses and end-of-page flag.
    always_comb begin
        mem_addr  = addr_q;
        lm_addr   = base_q + LM_AW'(off_q);
        last_word = (off_q == OFF_W'(PAGE_WORDS - 1));
        dir       = dir_q;
    end
endmodule

// File: rtl/dma_page_copy.sv
`timescale 1ns/1ps
// Page-fetch DMA engine top: accepts one CPU command, acquires the system
// bus, copies PAGE_WORDS words from main memory into a local RAM slot and
// pulses done.
// Assumes: page addresses are word aligned; the local RAM writes in the
// cycle lm_we is high; memory holds mem_rdata valid while mem_ack is high.
module dma_page_copy #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int CMD_W      = 4,
    parameter int PAGE_WORDS = 16,
    parameter int SLOTS      = 4,
    parameter logic [ADDR_W-1:0] DEV_ID = 'hA3,
    localparam int WORD_BYTES = DATA_W / 8,
    localparam int SLOT_W     = $clog2(SLOTS),
    localparam int OFF_W      = $clog2(PAGE_WORDS),
    localparam int LM_AW      = $clog2(SLOTS * PAGE_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [CMD_W-1:0]  cmd_ctrl,
    input  logic [ADDR_W-1:0] cmd_data,
    output logic              bus_req,
    input  logic              bus_grant,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_read,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              lm_we,
    output logic [LM_AW-1:0]  lm_addr,
    output logic [DATA_W-1:0] lm_wdata,
    output logic              busy,
    output logic              done,
    output logic              dir
);
    logic              accept;
    logic              idle;
    logic              dir_bit;
    logic [SLOT_W-1:0] slot;
    logic              word_take;
    logic              last_word;

    dma_cmd_decode #(
        .ADDR_W (ADDR_W),
        .CMD_W  (CMD_W),
        .SLOT_W (SLOT_W),
        .DEV_ID (DEV_ID)
    ) cmd_i (
        .cmd_valid (cmd_valid),
        .cmd_addr  (cmd_addr),
        .cmd_ctrl  (cmd_ctrl),
        .idle      (idle),
        .accept    (accept),
        .dir_bit   (dir_bit),
        .slot      (slot)
    );

    dma_seq_fsm seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .bus_grant (bus_grant),
        .mem_ack   (mem_ack),
        .last_word (last_word),
        .bus_req   (bus_req),
        .mem_read  (mem_read),
        .word_take (word_take),
        .busy      (busy),
        .done      (done),
        .idle      (idle)
    );

    dma_addr_gen #(
        .ADDR_W     (ADDR_W),
        .PAGE_WORDS (PAGE_WORDS),
        .WORD_BYTES (WORD_BYTES),
        .SLOT_W     (SLOT_W),
        .OFF_W      (OFF_W),
        .LM_AW      (LM_AW)
    ) agen_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .page_addr (cmd_data),
        .slot      (slot),
        .dir_in    (dir_bit),
        .step      (word_take),
        .mem_addr  (mem_addr),
        .lm_addr   (lm_addr),
        .last_word (last_word),
        .dir       (dir)
    );

    // Captured word goes straight through to the local RAM port.
    always_comb begin
        lm_we    = word_take;
        lm_wdata = mem_rdata;
    end
endmodule

// File: rtl/dma_page_copy_chk.sv
`timescale 1ns/1ps
// Protocol checker for dma_page_copy, attached with bind.
// Assumes: sampled on the rising clock edge; reset is synchronous active-low.
module dma_page_copy_chk #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_WORDS = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_grant,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_read,
    input logic              lm_we,
    input logic              busy,
    input logic              done,
    input logic              dir
);
    localparam int CW = $clog2(PAGE_WORDS + 1);

    logic [CW-1:0] wcnt_q;

    // Count local writes of the current page; cleared on the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || done) wcnt_q <= '0;
        else if (lm_we)     wcnt_q <= wcnt_q + 1'b1;
    end

    // R4
    read_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_read |-> (bus_grant && bus_req));

    // R3
    read_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_read) |-> $past(bus_req));

    // R8
    write_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lm_we |-> busy);

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !lm_we) |=> $stable(mem_addr));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !bus_req));

    // R7
    done_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (wcnt_q == CW'(PAGE_WORDS)));

    // R10
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(dir));
endmodule

bind dma_page_copy dma_page_copy_chk #(
    .ADDR_W     (ADDR_W),
    .PAGE_WORDS (PAGE_WORDS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_grant (bus_grant),
    .mem_addr  (mem_addr),
    .mem_read  (mem_read),
    .lm_we     (lm_we),
    .busy      (busy),
    .done      (done),
    .dir       (dir)
);

// File: tb/dma_page_copy_tb.sv
`timescale 1ns/1ps
// Bench for dma_page_copy: directed corner cases plus seeded random transfers
// with random grant drops and acknowledge delays.
module dma_page_copy_tb_top;
    localparam int PW    = 16;
    localparam int NSLOT = 4;
    localparam int LMD   = PW * NSLOT;
    localparam logic [31:0] MY_ID = 32'hA3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_addr = '0;
    logic [3:0]  cmd_ctrl = '0;
    logic [31:0] cmd_data = '0;
    logic        bus_req;
    logic        bus_grant = 1'b0;
    logic [31:0] mem_addr;
    logic        mem_read;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata;
    logic        lm_we;
    logic [5:0]  lm_addr;
    logic [31:0] lm_wdata;
    logic        busy;
    logic        done;
    logic        dir;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] lmem [LMD];

    always #10 clk = ~clk;

    dma_page_copy dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
        .cmd_ctrl(cmd_ctrl), .cmd_data(cmd_data), .bus_req(bus_req),
        .bus_grant(bus_grant), .mem_addr(mem_addr), .mem_read(mem_read),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .lm_we(lm_we),
        .lm_addr(lm_addr), .lm_wdata(lm_wdata), .busy(busy), .done(done),
        .dir(dir)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic [3:0] mk_ctrl(input bit go, input int slot, input bit d);
        return {go, slot[1:0], d};
    endfunction

    assign mem_rdata = mem_word(mem_addr);

    // Local cache RAM model.
    always @(posedge clk) if (lm_we) lmem[lm_addr] <= lm_wdata;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    task automatic send_cmd(input logic [31:0] id, input logic [3:0] ctrl,
                            input logic [31:0] page);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_addr = id; cmd_ctrl = ctrl; cmd_data = page;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic ignored_cmd(input logic [31:0] id, input logic [3:0] ctrl, input string why);
        send_cmd(id, ctrl, 32'h0000_4000);
        // R2: rejected command leaves the engine idle
        chk(!busy && !bus_req, "R2", why, {30'd0, busy, bus_req}, 32'd0);
        @(negedge clk);
        chk(!busy && !bus_req && !mem_read, "R2", {why, " (2nd cycle)"},
            {29'd0, busy, bus_req, mem_read}, 32'd0);
    endtask

    task automatic run_xfer(input logic [31:0] page, input int slot, input bit d,
                            input int gdelay, input int drop_pct, input int ack_pct,
                            input bit poke);
        int  off = 0;
        int  cyc = 0;
        bit  take;
        send_cmd(MY_ID, mk_ctrl(1'b1, slot, d), page);
        // R3 R8: request and busy the cycle after acceptance
        chk(busy && bus_req, "R3", "bus_req/busy after accept", {30'd0, busy, bus_req}, 32'd3);
        // R10: direction latched
        chk(dir == d, "R10", "dir latched", {31'd0, dir}, {31'd0, d});
        while (off < PW) begin
            if (cyc < gdelay) bus_grant = 1'b0;
            else              bus_grant = (($urandom % 100) >= drop_pct);
            if (poke && cyc == gdelay + 4) begin
                cmd_valid = 1'b1; cmd_addr = MY_ID;
                cmd_ctrl = mk_ctrl(1'b1, (slot + 1) % NSLOT, !d);
                cmd_data = page + 32'h0001_0000;
            end else begin
                cmd_valid = 1'b0;
            end
            #1;
            // R4 R6: no read without grant; R3: none before first grant
            if (!bus_grant)
                chk(!mem_read, "R6", "mem_read without grant", {31'd0, mem_read}, 32'd0);
            if (mem_read)
                chk(mem_addr == page + 32'(4 * off), "R4", "read address",
                    mem_addr, page + 32'(4 * off));
            if (mem_read) mem_ack = (($urandom % 100) < ack_pct);
            else          mem_ack = (($urandom % 3) == 0);
            #1;
            take = mem_read && mem_ack;
            // R5 R6: write exactly when a word is taken
            chk(lm_we == take, "R5", "lm_we vs read+ack", {31'd0, lm_we}, {31'd0, take});
            if (lm_we) begin
                chk(lm_addr == 6'(slot * PW + off), "R5", "lm_addr",
                    {26'd0, lm_addr}, 32'(slot * PW + off));
                chk(lm_wdata == mem_word(page + 32'(4 * off)), "R5", "lm_wdata",
                    lm_wdata, mem_word(page + 32'(4 * off)));
            end
            // R8: busy throughout
            chk(busy, "R8", "busy during transfer", {31'd0, busy}, 32'd1);
            @(negedge clk);
            cyc++;
            if (take) off++;
            if (cyc > 3000) begin
                chk(1'b0, "R7", "transfer never finished", 32'(off), 32'(PW));
                break;
            end
        end
        bus_grant = 1'b0; mem_ack = 1'b0; cmd_valid = 1'b0;
        // R7: done pulse one cycle after the final write, bus released
        chk(done && !busy && !bus_req, "R7", "done/busy/bus_req after last word",
            {29'd0, done, busy, bus_req}, 32'd4);
        @(negedge clk);
        chk(!done, "R7", "done lasts one cycle", {31'd0, done}, 32'd0);
        // R9 R10: mid-transfer command did not alter direction
        chk(dir == d, "R9", "dir unchanged by ignored command", {31'd0, dir}, {31'd0, d});
        for (int o = 0; o < PW; o++)
            chk(lmem[slot * PW + o] == mem_word(page + 32'(4 * o)), "R5", "local RAM content",
                lmem[slot * PW + o], mem_word(page + 32'(4 * o)));
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary_and_end();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < LMD; i++) lmem[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        chk(!busy && !bus_req && !mem_read && !lm_we && !done, "R1", "outputs in reset",
            {27'd0, busy, bus_req, mem_read, lm_we, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !bus_req && !mem_read && !lm_we && !done, "R1", "outputs after reset",
            {27'd0, busy, bus_req, mem_read, lm_we, done}, 32'd0);

        ignored_cmd(MY_ID ^ 32'h1, mk_ctrl(1'b1, 0, 1'b0), "wrong device ID");
        ignored_cmd(MY_ID, mk_ctrl(1'b0, 0, 1'b0), "start bit clear");

        // Directed: late grant, solid grant and ack, slot 0
        run_xfer(32'h0000_8000, 0, 1'b0, 3, 0, 100, 1'b0);
        // Directed: drops and slow acks, slot 3, dir set, poke while busy (R9)
        run_xfer(32'h1234_5600, 3, 1'b1, 1, 30, 40, 1'b1);
        // Random transfers
        for (int t = 0; t < 6; t++)
            run_xfer($urandom & 32'hFFFF_FFC0, int'($urandom % NSLOT), bit'($urandom % 2),
                     int'($urandom % 4), int'($urandom % 40), 30 + int'($urandom % 70),
                     bit'($urandom % 2));

        summary_and_end();
    end
endmodule